// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the eight status flags of an asynchronous serial port and presents them as one byte to a processor over a small register bus. The transmit and receive engines send it single-cycle event pulses: a character moved from the transmit buffer into the shifter, a character moved from the receive shifter into the buffer, and receive errors (overrun, noise, framing, parity). It also watches the sampled receive line at each bit-clock tick, so it can detect an idle line.

Most flags are sticky. Software clears one in two steps: a status read that sees the flag set, then an access to the data register. A data write clears the transmitter-empty flag. A data read clears the receive-side flags. Each flag remembers on its own whether the last status read saw it set. A flag that rises between the two steps therefore survives. The transmit and receive interrupt requests are formed from the flags and four enable inputs.

Top module: `serial_status_flags`

## Requirements
- R1: After reset, `status_o` reads 8'hC0: transmitter empty and transmission complete are 1, and the other six flags are 0.
- R2: The status byte holds, from bit 7 down to bit 0: transmitter empty, transmission complete, receiver full, idle, overrun, noise, framing error, parity error.
- R3: `tx_load_evt` sets transmitter empty (bit 7) on the next cycle. The flag clears only when a status read (`acc_addr`=0, `acc_write`=0) that saw it set is followed by a data write (`acc_addr`=1, `acc_write`=1). A data read does not clear it.
- R4: Transmission complete (bit 6) equals transmitter empty AND NOT `tx_pending`, in the same cycle. `tx_pending` is high while data, preamble or break is queued or being sent, including the start-up delay.
- R5: `rx_load_evt` sets receiver full (bit 5) on the next cycle. The flag clears when a status read that saw it set is followed by a data read (`acc_addr`=1, `acc_write`=0). A data write does not clear it.
- R6: Overrun (bit 3), noise (bit 2), framing (bit 1) and parity (bit 0) are set by `ovr_evt`, `noise_evt`, `frame_evt` and `parity_evt` and clear like receiver full. Each flag keeps its own record of the last status read, so a flag set after that read survives the data read.
- R7: Idle (bit 4) is set after a run of consecutive 1s sampled on `rx_line` at `bit_tick`. The run length is 10 when `long_frame`=0 and 11 when `long_frame`=1. A 0 sampled at a tick restarts the count. Idle clears like receiver full.
- R8: Idle is armed only by a received character (`rx_load_evt`) since the last time it was set. It is not armed out of reset. A line that stays high, or a new run without a character, does not set it again.
- R9: `tx_irq` = (bit 7 AND `te_irq_en`) OR (bit 6 AND `tc_irq_en`). `rx_irq` = (bit 5 AND `rf_irq_en`) OR (bit 4 AND `idle_irq_en`).
- R10: When a set event and a clearing data access fall in the same cycle, the flag stays set.
- R11: Writes to the status address change no flag. A data access that was not preceded by a status read that saw the flag set clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Bus access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = status register, 1 = data register |
| tx_load_evt | input | 1 | Transmit buffer moved a character into the shifter |
| tx_pending | input | 1 | Data, preamble or break queued or being sent |
| rx_load_evt | input | 1 | Receive shifter moved a character into the buffer |
| ovr_evt | input | 1 | Overrun detected |
| noise_evt | input | 1 | Noise detected |
| frame_evt | input | 1 | Framing error detected |
| parity_evt | input | 1 | Parity error detected |
| rx_line | input | 1 | Sampled receive line |
| bit_tick | input | 1 | One pulse per receive bit period |
| long_frame | input | 1 | Selects the 11-bit idle run instead of the 10-bit run |
| te_irq_en | input | 1 | Transmitter-empty interrupt enable |
| tc_irq_en | input | 1 | Transmission-complete interrupt enable |
| rf_irq_en | input | 1 | Receiver-full interrupt enable |
| idle_irq_en | input | 1 | Idle interrupt enable |
| status_o | output | 8 | Status byte |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench uses the default idle run lengths of 10 and 11. These are short enough to sweep run lengths from 8 to 12 ones under both frame settings, which covers just-below, exact and beyond threshold. It sweeps all 32 combinations of the five receive event flags, both as direct set patterns and as a split between flags seen by the status read and flags set after it. All 16 interrupt-enable combinations are checked with transmission complete both set and cleared.

// File: rtl/ssf_pkg.sv
// Shared constants for the serial status flag controller.
// Assumes an 8-bit status byte; the bit positions are decoded by software.
package ssf_pkg;
    localparam int STAT_W = 8;
    localparam int B_TE   = 7;
    localparam int B_TC   = 6;
    localparam int B_RF   = 5;
    localparam int B_IDLE = 4;
    localparam int B_OR   = 3;
    localparam int B_NF   = 2;
    localparam int B_FE   = 1;
    localparam int B_PE   = 0;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_STAT_RD,
        ACC_DATA_RD,
        ACC_DATA_WR
    } acc_kind_e;
endpackage

// File: rtl/ssf_bus_decode.sv
// Decodes one bus access into a single access kind.
// Assumes at most one access per cycle. Status writes decode to ACC_NONE
// because every status bit is read-only.
module ssf_bus_decode
    import ssf_pkg::*;
(
    input  logic      acc_valid,
    input  logic      acc_write,
    input  logic      acc_addr,
    output acc_kind_e kind_o
);
    // Map address and direction onto an access kind.
    always_comb begin
        kind_o = ACC_NONE;
        if (acc_valid) begin
            if (!acc_addr && !acc_write) kind_o = ACC_STAT_RD;
            else if (acc_addr && !acc_write) kind_o = ACC_DATA_RD;
            else if (acc_addr && acc_write) kind_o = ACC_DATA_WR;
        end
    end
endmodule

// File: rtl/ssf_flag_cell.sv
// One sticky status flag with two-step clearing.
// A status read records whether the flag was set. A later clearing access
// drops the flag only if that record is set, and the access consumes the
// record. A set pulse always wins over a clear in the same cycle.
module ssf_flag_cell #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic snap_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;
    logic seen_q;

    // Flag state: set has priority over a qualified clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= RST_VAL;
        else if (set_i)             flag_q <= 1'b1;
        else if (clr_i && seen_q)   flag_q <= 1'b0;
    end

    // Set-at-read record: captured on status read, consumed on clearing access.
    always_ff @(posedge clk) begin
        if (!rst_n)      seen_q <= 1'b0;
        else if (snap_i) seen_q <= flag_q;
        else if (clr_i)  seen_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ssf_idle_det.sv
// Receive-line idle detector.
// Counts consecutive ones sampled at bit ticks and saturates at the selected
// run length. It pulses once when the run reaches that length, and only
// while armed. A received character arms it; the pulse disarms it.
module ssf_idle_det #(
    parameter int RUN_SHORT = 10,
    parameter int RUN_LONG  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic bit_tick,
    input  logic long_frame,
    input  logic char_done,
    output logic idle_evt
);
    localparam int RUN_MAX = (RUN_LONG > RUN_SHORT) ? RUN_LONG : RUN_SHORT;
    localparam int CNT_W   = $clog2(RUN_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             armed_q;

    assign limit    = long_frame ? CNT_W'(RUN_LONG) : CNT_W'(RUN_SHORT);
    assign idle_evt = bit_tick && rx_line && armed_q && (cnt_q == limit - CNT_W'(1));

    // Run counter of ones, restarted by any sampled zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (bit_tick) begin
            if (!rx_line)         cnt_q <= '0;
            else if (cnt_q < limit) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Arming: a character enables one idle detection.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (char_done) armed_q <= 1'b1;
        else if (idle_evt)  armed_q <= 1'b0;
    end
endmodule

// File: rtl/serial_status_flags.sv
// Status flag controller of an asynchronous serial port.
// Holds eight flags, clears them through status-read-then-data-access
// sequences, and forms transmit and receive interrupt requests.
// Assumes single-cycle event pulses and at most one bus access per cycle.
module serial_status_flags
    import ssf_pkg::*;
#(
    parameter int IDLE_RUN_SHORT = 10,
    parameter int IDLE_RUN_LONG  = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_addr,
    input  logic       tx_load_evt,
    input  logic       tx_pending,
    input  logic       rx_load_evt,
    input  logic       ovr_evt,
    input  logic       noise_evt,
    input  logic       frame_evt,
    input  logic       parity_evt,
    input  logic       rx_line,
    input  logic       bit_tick,
    input  logic       long_frame,
    input  logic       te_irq_en,
    input  logic       tc_irq_en,
    input  logic       rf_irq_en,
    input  logic       idle_irq_en,
    output logic [7:0] status_o,
    output logic       tx_irq,
    output logic       rx_irq
);
    acc_kind_e          kind;
    logic               idle_evt;
    logic [STAT_W-1:0]  set_vec;
    logic [STAT_W-1:0]  flags;

    ssf_bus_decode u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .kind_o    (kind)
    );

    ssf_idle_det #(
        .RUN_SHORT (IDLE_RUN_SHORT),
        .RUN_LONG  (IDLE_RUN_LONG)
    ) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .bit_tick   (bit_tick),
        .long_frame (long_frame),
        .char_done  (rx_load_evt),
        .idle_evt   (idle_evt)
    );

    // Route each event pulse to its flag position.
    always_comb begin
        set_vec         = '0;
        set_vec[B_TE]   = tx_load_evt;
        set_vec[B_RF]   = rx_load_evt;
        set_vec[B_IDLE] = idle_evt;
        set_vec[B_OR]   = ovr_evt;
        set_vec[B_NF]   = noise_evt;
        set_vec[B_FE]   = frame_evt;
        set_vec[B_PE]   = parity_evt;
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_flag
        if (b == B_TC) begin : g_tc
            assign flags[b] = flags[B_TE] && !tx_pending;
        end else begin : g_cell
            localparam acc_kind_e CLR_KIND = (b == B_TE) ? ACC_DATA_WR : ACC_DATA_RD;
            ssf_flag_cell #(
                .RST_VAL (b == B_TE)
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[b]),
                .snap_i (kind == ACC_STAT_RD),
                .clr_i  (kind == CLR_KIND),
                .flag_o (flags[b])
            );
        end
    end

    assign status_o = flags;
    assign tx_irq   = (flags[B_TE] && te_irq_en) || (flags[B_TC] && tc_irq_en);
    assign rx_irq   = (flags[B_RF] && rf_irq_en) || (flags[B_IDLE] && idle_irq_en);
endmodule

// File: rtl/serial_status_flags_chk.sv
// Property checker for serial_status_flags, attached by bind.
module serial_status_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_write,
    input logic       acc_addr,
    input logic       tx_load_evt,
    input logic       tx_pending,
    input logic       rx_load_evt,
    input logic       ovr_evt,
    input logic       noise_evt,
    input logic       frame_evt,
    input logic       parity_evt,
    input logic       bit_tick,
    input logic [7:0] status_o
);
    logic any_set;
    assign any_set = tx_load_evt | rx_load_evt | ovr_evt | noise_evt |
                     frame_evt | parity_evt | bit_tick;

    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_o == 8'hC0) || tx_pending);

    a_r3_te_set: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_evt |=> status_o[7]);

    a_r4_tc_pending_low: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pending |-> !status_o[6]);

    a_r10_rf_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load_evt |=> status_o[5]);

    a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && noise_evt && frame_evt && parity_evt) |=> (status_o[3:0] == 4'hF));

    a_r11_status_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_addr && !any_set) |=>
        $stable({status_o[7], status_o[5:0]}));
endmodule

bind serial_status_flags serial_status_flags_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .tx_load_evt (tx_load_evt),
    .tx_pending  (tx_pending),
    .rx_load_evt (rx_load_evt),
    .ovr_evt     (ovr_evt),
    .noise_evt   (noise_evt),
    .frame_evt   (frame_evt),
    .parity_evt  (parity_evt),
    .bit_tick    (bit_tick),
    .status_o    (status_o)
);

// File: tb/serial_status_flags_tb_top.sv
// Self-checking bench for serial_status_flags.
module serial_status_flags_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 0, acc_write = 0, acc_addr = 0;
    logic tx_load_evt = 0, tx_pending = 0, rx_load_evt = 0;
    logic ovr_evt = 0, noise_evt = 0, frame_evt = 0, parity_evt = 0;
    logic rx_line = 1, bit_tick = 0, long_frame = 0;
    logic te_irq_en = 0, tc_irq_en = 0, rf_irq_en = 0, idle_irq_en = 0;
    logic [7:0] status_o;
    logic tx_irq, rx_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    serial_status_flags dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus access: kind 1 status read, 2 data read, 3 data write, 4 status write.
    task automatic bus(input int kind);
        @(negedge clk);
        acc_valid = 1;
        acc_addr  = (kind == 2 || kind == 3);
        acc_write = (kind == 3 || kind == 4);
        @(negedge clk);
        acc_valid = 0; acc_addr = 0; acc_write = 0;
    endtask

    // Pulse receive events {rx_load, ovr, noise, frame, parity}.
    task automatic rx_ev(input logic [4:0] m);
        @(negedge clk);
        {rx_load_evt, ovr_evt, noise_evt, frame_evt, parity_evt} = m;
        @(negedge clk);
        {rx_load_evt, ovr_evt, noise_evt, frame_evt, parity_evt} = '0;
    endtask

    task automatic tick(input logic v);
        @(negedge clk);
        rx_line = v; bit_tick = 1;
        @(negedge clk);
        bit_tick = 0; rx_line = 1;
    endtask

    task automatic clear_rx();
        bus(1); bus(2);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1, R2 reset value
        check("R1 reset status", status_o, 8'hC0);
        check("R1 reset irqs", {tx_irq, rx_irq}, 0);

        // R3/R4: clear TE, reload, pending behaviour
        bus(2);
        check("R3 data read keeps TE", status_o, 8'hC0);
        bus(3);
        check("R11 data write without status read keeps TE", status_o, 8'hC0);
        bus(1); bus(3);
        check("R3 TE cleared, R4 TC follows", status_o, 8'h00);
        @(negedge clk); tx_pending = 1; tx_load_evt = 1;
        @(negedge clk); tx_load_evt = 0;
        check("R3 TE set, R4 TC low while pending", status_o, 8'h80);
        tx_pending = 0; #1;
        check("R4 TC high once idle", status_o, 8'hC0);

        // R9 sweep of enables with TC set and cleared, RF set
        rx_ev(5'b10000);
        for (int p = 0; p < 2; p++) begin
            for (int en = 0; en < 16; en++) begin
                @(negedge clk);
                tx_pending = p[0];
                {idle_irq_en, rf_irq_en, tc_irq_en, te_irq_en} = en[3:0];
                #1;
                check("R9 tx_irq", tx_irq, en[0] | (en[1] & ~p[0]));
                check("R9 rx_irq", rx_irq, en[2]);
            end
        end
        tx_pending = 0;
        {idle_irq_en, rf_irq_en, tc_irq_en, te_irq_en} = '0;
        clear_rx();

        // R5, R6 set-pattern sweep
        for (int m = 0; m < 32; m++) begin
            rx_ev(m[4:0]);
            check("R5 R6 flags set", status_o & 8'h2F, {2'b11, m[4], 1'b0, m[3:0]} & 8'h2F);
            clear_rx();
            check("R5 R6 flags cleared", status_o, 8'hC0);
        end

        // R6: seen-at-read split, flags set after the read survive
        for (int a = 0; a < 32; a++) begin
            rx_ev(a[4:0]);
            bus(1);
            rx_ev(~a[4:0]);
            bus(2);
            check("R6 late flags survive", status_o & 8'h2F,
                  {2'b00, ~a[4], 1'b0, ~a[3:0]} & 8'h2F);
            clear_rx();
        end

        // R11: status write and wrong order leave flags alone
        rx_ev(5'b11111);
        bus(4);
        check("R11 status write ignored", status_o, 8'hEF);
        bus(2); bus(1);
        check("R11 data read before status read", status_o, 8'hEF);
        // R10: set event and clearing access in the same cycle
        @(negedge clk);
        acc_valid = 1; acc_addr = 1; rx_load_evt = 1;
        @(negedge clk);
        acc_valid = 0; acc_addr = 0; rx_load_evt = 0;
        check("R10 set wins over clear", status_o, 8'hE0);
        bus(2);
        check("R11 record consumed", status_o, 8'hE0);
        clear_rx();
        check("R5 cleared", status_o, 8'hC0);

        // R7 idle run-length sweep
        idle_irq_en = 1;
        for (int lf = 0; lf < 2; lf++) begin
            long_frame = lf[0];
            for (int n = 8; n <= 12; n++) begin
                tick(0);
                rx_ev(5'b10000);
                for (int k = 0; k < n; k++) tick(1);
                check("R7 idle after run", status_o[4], (n >= 10 + lf) ? 1 : 0);
                check("R9 rx_irq from idle", rx_irq, (n >= 10 + lf) ? 1 : 0);
                clear_rx();
                check("R7 idle cleared", status_o, 8'hC0);
            end
        end
        // R8: no new character, no new idle
        long_frame = 0;
        tick(0);
        for (int k = 0; k < 12; k++) tick(1);
        check("R8 no retrigger without character", status_o[4], 0);
        rx_ev(5'b10000);
        for (int k = 0; k < 3; k++) tick(1);
        check("R8 saturated run does not fire", status_o[4], 0);
        tick(0);
        for (int k = 0; k < 10; k++) tick(1);
        check("R8 rearmed by character", status_o[4], 1);
        clear_rx();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule